// File: doc/BRIEF.md
# Sequenced-Service Watchdog Timer

This block is a watchdog for a system whose software must prove it is running in the intended order. A free-running counter advances on every clock while the watchdog is enabled. If software does not service it before the selected period runs out, the block raises a one-cycle reset request for the system reset logic.

Servicing takes two byte writes to one service location. The arming byte 0x55 comes first and the commit byte 0xAA second. Only that ordered pair restarts the count. Any other byte written while the watchdog is enabled is treated as a sign of runaway code, and the block requests a reset at once. A reason output tells the reset logic which of the two causes fired.

A 3-bit rate code picks the period. Code 0 turns the watchdog off. Codes 1 to 7 select periods that grow by a factor of four per step. A parameter sets the shortest period, so a simulation can use short windows.

Top module: `wdog_seq_service`

## Requirements
- R1: While reset is held and on the first cycle after it is released, `rst_req` is 0 and `rst_cause` is 0.
- R2: Rate code k (1 to 7) sets a period of 2^(BASE_LOG2 + 2*(k-1)) clock cycles. With no service, `rst_req` pulses exactly one period after the last restart, and then again every period.
- R3: Rate code 0 disables the block. The counter does not run and `rst_req` stays 0. Writes to the service register are ignored, including bytes that would otherwise be bad keys.
- R4: Writing 0xAA while armed by an earlier 0x55 is a service. The count restarts at that write, so the next time-out comes one full period after it.
- R5: Writing 0xAA while not armed is neither a service nor an error. The count keeps running and no reset is requested.
- R6: Writing 0x55 while already armed keeps the block armed and does not restart the count.
- R7: Writing any byte other than 0x55 or 0xAA while enabled raises `rst_req` on the next cycle with `rst_cause` = 1. It also clears the armed state and restarts the count.
- R8: `rst_req` lasts one cycle per event. `rst_cause` is 0 for a time-out and 1 for a bad key, and it is valid while `rst_req` is high.
- R9: Changing the rate code restarts the count under the new period and clears the armed state.
- R10: A service written in the last cycle of the period wins over the time-out, and no reset is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rate_sel | input | 3 | Time-out rate code, 0 disables |
| svc_wr | input | 1 | Write strobe for the service register |
| svc_data | input | 8 | Byte written to the service register |
| rst_req | output | 1 | One-cycle system reset request |
| rst_cause | output | 1 | 0 = time-out, 1 = bad key |

## Verification
The bench runs with a short base period. It measures the exact distance in cycles from each restart to the next time-out pulse for every rate code, so an off-by-one terminal count or a wrong rate step shows up as a wrong distance. It writes all 256 byte values to the service register and checks which ones fire a bad-key reset. It also runs the ordering cases: 0xAA before 0x55, a doubled 0x55, and a rate change between the two key bytes. A design that accepted an unarmed 0xAA, restarted on 0x55, or kept the armed state across a rate change would time out at a different cycle than the one predicted. A service in the very last cycle of the period is tried as well, and so is a disabled block fed bad bytes. Either case would produce a spurious reset in a design that ordered its priorities wrongly or failed to gate the service register when disabled.

// File: rtl/wdog_pkg.sv
// Shared constants and types for the sequenced-service watchdog.
// Assumes: one service write per cycle at most.
package wdog_pkg;
    localparam int          RATE_W   = 3;
    localparam int          NUM_RATE = 7;
    localparam logic [7:0]  KEY_ARM  = 8'h55;
    localparam logic [7:0]  KEY_DONE = 8'hAA;

    typedef enum logic {
        CAUSE_TIMEOUT = 1'b0,
        CAUSE_BADKEY  = 1'b1
    } wd_cause_e;
endpackage

// File: rtl/wdog_term_sel.sv
// Maps the rate code onto a terminal count and an enable flag.
// Assumes: code 0 disables; code k selects 2^(BASE_LOG2+STEP_LOG2*(k-1)) cycles.
module wdog_term_sel #(
    parameter int BASE_LOG2 = 13,
    parameter int STEP_LOG2 = 2,
    parameter int CNT_W     = BASE_LOG2 + STEP_LOG2 * (wdog_pkg::NUM_RATE - 1)
) (
    input  logic [wdog_pkg::RATE_W-1:0] rate_sel,
    output logic                        en,
    output logic [CNT_W-1:0]            term
);
    logic [CNT_W-1:0] term_tab [wdog_pkg::NUM_RATE];

    // One terminal count per rate code, all computed from the parameters.
    for (genvar k = 0; k < wdog_pkg::NUM_RATE; k++) begin : g_term
        localparam int SH = CNT_W - (BASE_LOG2 + STEP_LOG2 * k);
        assign term_tab[k] = {CNT_W{1'b1}} >> SH;
    end

    // Pick the terminal count for the active code.
    always_comb begin
        en   = (rate_sel != '0);
        term = '0;
        for (int k = 0; k < wdog_pkg::NUM_RATE; k++) begin
            if (rate_sel == wdog_pkg::RATE_W'(k + 1)) term = term_tab[k];
        end
    end
endmodule

// File: rtl/wdog_key_seq.sv
// Tracks the two-byte service key and classifies each write.
// Assumes: writes are ignored when disabled; clr drops the armed state.
module wdog_key_seq (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       clr,
    input  logic       svc_wr,
    input  logic [7:0] svc_data,
    output logic       svc_ok,
    output logic       bad_key
);
    logic armed_q;
    logic wr_en, is_arm, is_done;

    // Decode the written byte.
    always_comb begin
        wr_en   = en && svc_wr;
        is_arm  = (svc_data == wdog_pkg::KEY_ARM);
        is_done = (svc_data == wdog_pkg::KEY_DONE);
        svc_ok  = wr_en && is_done && armed_q;
        bad_key = wr_en && !is_arm && !is_done;
    end

    // Armed state: set by 0x55, dropped by any other write, clear or disable.
    always_ff @(posedge clk) begin
        if (!rst_n)           armed_q <= 1'b0;
        else if (clr || !en)  armed_q <= 1'b0;
        else if (wr_en)       armed_q <= is_arm;
    end
endmodule

// File: rtl/wdog_tick_cnt.sv
// Free-running period counter with a restart input and a terminal flag.
// Assumes: held at zero while disabled.
module wdog_tick_cnt #(
    parameter int CNT_W = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             restart,
    input  logic [CNT_W-1:0] term,
    output logic [CNT_W-1:0] cnt_q,
    output logic             expire
);
    // Flag the final cycle of the period.
    assign expire = en && (cnt_q == term);

    // Count up, or return to zero on restart, disable or reset.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || restart) cnt_q <= '0;
        else                          cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/wdog_seq_service.sv
// Sequenced-service watchdog top: rate decode, key tracking, counting and
// a registered one-cycle reset request with its cause.
// Assumes: the reset sequencer acts on rst_req; rst_cause is valid with it.
module wdog_seq_service #(
    parameter int BASE_LOG2 = 13,
    parameter int STEP_LOG2 = 2,
    localparam int CNT_W    = BASE_LOG2 + STEP_LOG2 * (wdog_pkg::NUM_RATE - 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] rate_sel,
    input  logic       svc_wr,
    input  logic [7:0] svc_data,
    output logic       rst_req,
    output logic       rst_cause
);
    import wdog_pkg::*;

    logic [2:0]       rate_q;
    logic             rate_chg, en, svc_ok, bad_key, expire, tmo, fire, restart;
    logic [CNT_W-1:0] term, cnt_q;
    wd_cause_e        cause;

    // Remember the previous rate code to spot changes.
    always_ff @(posedge clk) begin
        rate_q <= rate_sel;
    end

    wdog_term_sel #(.BASE_LOG2(BASE_LOG2), .STEP_LOG2(STEP_LOG2), .CNT_W(CNT_W)) u_term (
        .rate_sel (rate_sel),
        .en       (en),
        .term     (term)
    );

    wdog_key_seq u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .clr      (rate_chg || tmo),
        .svc_wr   (svc_wr),
        .svc_data (svc_data),
        .svc_ok   (svc_ok),
        .bad_key  (bad_key)
    );

    wdog_tick_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .restart (restart),
        .term    (term),
        .cnt_q   (cnt_q),
        .expire  (expire)
    );

    // Event priority: a bad key beats all; a service or rate change cancels a time-out.
    always_comb begin
        rate_chg = (rate_q != rate_sel);
        tmo      = expire && !rate_chg && !svc_ok;
        fire     = bad_key || tmo;
        restart  = rate_chg || svc_ok || fire;
        cause    = bad_key ? CAUSE_BADKEY : CAUSE_TIMEOUT;
    end

    // Register the request pulse and latch its cause.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_req   <= 1'b0;
            rst_cause <= 1'b0;
        end else begin
            rst_req <= fire;
            if (fire) rst_cause <= cause;
        end
    end
endmodule

// File: rtl/wdog_seq_service_chk.sv
// Property checker for the sequenced-service watchdog, bound to the top.
// Assumes: svc_ok and cnt_q are the top's service and counter signals.
module wdog_seq_service_chk #(
    parameter int CNT_W = 25
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       rate_sel,
    input logic             svc_wr,
    input logic [7:0]       svc_data,
    input logic             rst_req,
    input logic             rst_cause,
    input logic             svc_ok,
    input logic [CNT_W-1:0] cnt_q
);
    logic good_wr, bad_wr;
    assign good_wr = svc_wr && (rate_sel != 3'd0) && (svc_data == 8'h55 || svc_data == 8'hAA);
    assign bad_wr  = svc_wr && (rate_sel != 3'd0) && !(svc_data == 8'h55 || svc_data == 8'hAA);

    AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_sel == 3'd0) |=> !rst_req); // R3
    AST_BADKEY_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        bad_wr |=> (rst_req && rst_cause)); // R7
    AST_GOODKEY_NOT_BAD: assert property (@(posedge clk) disable iff (!rst_n)
        good_wr |=> !(rst_req && rst_cause)); // R8
    AST_SERVICE_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        svc_ok |=> (cnt_q == '0)); // R4
    AST_SERVICE_BEATS_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
        svc_ok |=> !rst_req); // R10
    AST_RATE_CHANGE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_sel != $past(rate_sel)) |=> (cnt_q == '0)); // R9
endmodule

bind wdog_seq_service wdog_seq_service_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rate_sel  (rate_sel),
    .svc_wr    (svc_wr),
    .svc_data  (svc_data),
    .rst_req   (rst_req),
    .rst_cause (rst_cause),
    .svc_ok    (svc_ok),
    .cnt_q     (cnt_q)
);

// File: tb/tb_wdog_seq_service.sv
// Self-checking bench: short base period, cycle-exact time-out distances.
module tb_wdog_seq_service;
    localparam int CLK_PERIOD = 10;
    localparam int BASE       = 3;
    localparam int WD_LIMIT   = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] rate_sel = 3'd0;
    logic       svc_wr = 1'b0;
    logic [7:0] svc_data = 8'h00;
    logic       rst_req, rst_cause;

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit done = 1'b0;

    wdog_seq_service #(.BASE_LOG2(BASE), .STEP_LOG2(2)) dut (
        .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .svc_wr(svc_wr),
        .svc_data(svc_data), .rst_req(rst_req), .rst_cause(rst_cause)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int period(input int k);
        return 1 << (BASE + 2 * (k - 1));
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > WD_LIMIT && !done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, WD_LIMIT);
            finish_run();
        end
    end

    task automatic step();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic set_rate(input int k);
        rate_sel = 3'(k);
        step();
    endtask

    task automatic restart_at(input int k);
        set_rate(0);
        set_rate(k);
    endtask

    task automatic wr(input logic [7:0] v);
        svc_wr = 1'b1; svc_data = v;
        step();
        svc_wr = 1'b0;
    endtask

    // Idle n cycles; any pulse there is a failure for req.
    task automatic idle_quiet(input int n, input string req);
        int hits = 0;
        for (int i = 0; i < n; i++) begin
            step();
            if (rst_req) hits++;
        end
        chk(hits == 0, req, hits, 0);
    endtask

    // Count cycles until the next pulse.
    task automatic wait_pulse(output int n, input int cap);
        n = 0;
        while (n < cap) begin
            step();
            n++;
            if (rst_req) return;
        end
        n = -1;
    endtask

    initial begin
        int n;
        @(negedge clk);
        repeat (3) begin
            chk(rst_req == 1'b0 && rst_cause == 1'b0, "R1 in reset", rst_req, 0);
            step();
        end
        rate_sel = 3'd1;
        step();
        rst_n = 1'b1;
        chk(rst_req == 1'b0 && rst_cause == 1'b0, "R1 after release", rst_req, 0);

        // R2: every rate code, exact distance from the restart edge.
        for (int k = 1; k <= 7; k++) begin
            restart_at(k);
            wait_pulse(n, period(k) + 4);
            chk(n == period(k), $sformatf("R2 period code %0d", k), n, period(k));
            chk(rst_cause == 1'b0, "R8 timeout cause", rst_cause, 0);
        end
        // R2/R8: periodic repeat and single-cycle pulse at code 1.
        restart_at(1);
        wait_pulse(n, 40);
        wait_pulse(n, 40);
        chk(n == period(1), "R8 pulse one cycle, R2 repeat", n, period(1));

        // R4: ordered key restarts the count.
        restart_at(2);
        idle_quiet(20, "R4 before service");
        wr(8'h55); idle_quiet(5, "R4 armed wait"); wr(8'hAA);
        chk(rst_req == 1'b0, "R4 service no reset", rst_req, 0);
        wait_pulse(n, 80);
        chk(n == period(2), "R4 restart on service", n, period(2));

        // R5: unarmed 0xAA is not a service.
        restart_at(2);
        idle_quiet(10, "R5 idle");
        wr(8'hAA);
        chk(rst_req == 1'b0, "R5 unarmed AA no reset", rst_req, 0);
        wait_pulse(n, 80);
        chk(n == period(2) - 11, "R5 count kept running", n, period(2) - 11);

        // R6: doubled 0x55 neither restarts nor disarms.
        restart_at(2);
        idle_quiet(4, "R6 idle"); wr(8'h55); idle_quiet(3, "R6 idle"); wr(8'h55);
        wait_pulse(n, 80);
        chk(n == period(2) - 9, "R6 double 55 no restart", n, period(2) - 9);
        restart_at(2);
        wr(8'h55); wr(8'h55); wr(8'hAA);
        wait_pulse(n, 80);
        chk(n == period(2), "R6 still armed after 55 55", n, period(2));

        // R7: bad key fires at once with cause 1 and restarts the count.
        restart_at(2);
        idle_quiet(5, "R7 idle");
        wr(8'h12);
        chk(rst_req == 1'b1 && rst_cause == 1'b1, "R7 bad key pulse", {rst_req, rst_cause}, 3);
        wait_pulse(n, 80);
        chk(n == period(2), "R7 restart after bad key", n, period(2));
        chk(rst_cause == 1'b0, "R8 cause back to timeout", rst_cause, 0);

        // R7/R8: sweep every byte value at the longest rate.
        restart_at(7);
        for (int v = 0; v < 256; v++) begin
            bit good;
            good = (v == 8'h55) || (v == 8'hAA);
            wr(8'(v));
            chk(rst_req == !good && (good || rst_cause == 1'b1),
                $sformatf("R7 byte %0h", v), rst_req, !good);
            step();
            chk(rst_req == 1'b0, "R8 single cycle", rst_req, 0);
        end

        // R9: rate change clears the armed state and restarts.
        restart_at(2);
        wr(8'h55);
        set_rate(3);
        wr(8'hAA);
        chk(rst_req == 1'b0, "R9 AA after change no reset", rst_req, 0);
        wait_pulse(n, 200);
        chk(n == period(3) - 1, "R9 disarmed by rate change", n, period(3) - 1);

        // R10: service in the final cycle of the period wins.
        restart_at(1);
        idle_quiet(5, "R10 idle"); wr(8'h55); idle_quiet(1, "R10 idle"); wr(8'hAA);
        chk(rst_req == 1'b0, "R10 last-cycle service", rst_req, 0);
        wait_pulse(n, 40);
        chk(n == period(1), "R10 restart from last cycle", n, period(1));

        // R3: disabled block ignores bad bytes and never times out.
        restart_at(1);
        idle_quiet(5, "R3 idle");
        set_rate(0);
        chk(rst_req == 1'b0, "R3 disable", rst_req, 0);
        wr(8'h00);
        chk(rst_req == 1'b0, "R3 bad byte ignored", rst_req, 0);
        wr(8'h3C);
        chk(rst_req == 1'b0, "R3 bad byte ignored", rst_req, 0);
        idle_quiet(100, "R3 no timeout when off");

        finish_run();
    end
endmodule